// File: doc/BRIEF.md
# Clock Synthesizer Lock-Control Register and Sequencer

This block holds one 16-bit control and status word for a clock synthesizer. It also runs a small mode sequencer that picks which clock drives the output. In bypass the output selection points at the divided reference clock. In locked mode it points at the synthesized clock. The block stores the multiply, divide and bypass-divide settings and forwards them to the synthesizer core. It asks the core to start a lock sequence with a single-cycle request. The sequencer moves to locked mode once the core reports that the target frequency has been reached.

Every register write forces the selection back to bypass at once. If the written enable bit is set, the write also restarts the lock sequence, so the multiply and divide values cannot change under a running synthesized clock. A policy bit decides what happens when the core loses lock in locked mode. With the bit set, the sequencer drops to bypass and relocks. With it clear, the synthesized clock stays selected and an active-low break flag is pulled low until lock returns or software writes the register.

The asynchronous active-low reset is released through a two-stage synchronizer. The sequencer therefore acts on the third rising clock edge after the reset input goes high.

Top module: `clksyn_mode_ctrl`

## Requirements
- R1: The read word resets to 0x2012: relock policy bit 13 = 1, enable bit 4 = 1, break flag bit 1 = 1, multiply, divide, bypass-divide and lock bit 0 all 0, and the bypass clock selected.
- R2: Bits 15, 14 and 12 ignore writes and always read 0.
- R3: A write stores multiply (bits 11:7), divide (bits 6:5) and bypass-divide (bits 3:2). These fields read back and drive the core-facing outputs, and they hold between writes.
- R4: In the cycle after any write, the bypass clock is selected (sel_synth_o = 0, lock bit = 0), whatever state the sequencer was in.
- R5: A write with enable (bit 4) = 1 enters the locking state, and lock_req_o pulses high for exactly the first cycle of that state. Out of reset, with enable at its reset value of 1, the same entry and pulse occur three rising edges after reset release.
- R6: From locking, freq_ok_i = 1 at a rising edge enters locked mode on that edge. Locked mode is the only state in which sel_synth_o and lock bit 0 read 1.
- R7: A write with enable = 0 returns to bypass and raises no lock request. The block stays in bypass until a later write sets enable.
- R8: In locked mode with the relock policy bit = 1, core_locked_i = 0 moves the block to locking, selects bypass and pulses lock_req_o.
- R9: In locked mode with the relock policy bit = 0, core_locked_i = 0 keeps the synthesized clock selected and drives break flag bit 1 to 0.
- R10: The break flag returns to 1 in the cycle after core_locked_i = 1 is seen or a write occurs.
- R11: freq_ok_i has no effect outside the locking state, and a write in the same cycle as freq_ok_i takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Register read word, including status bits |
| freq_ok_i | input | 1 | Core reports target frequency synthesized |
| core_locked_i | input | 1 | Core lock indication, 0 means lock lost |
| sel_synth_o | output | 1 | 1 selects the synthesized clock, 0 the bypass clock |
| lock_req_o | output | 1 | Single-cycle request to the core to start locking |
| mult_o | output | 5 | Multiply setting to the core |
| div_o | output | 2 | Divide setting to the core |
| bypass_div_o | output | 2 | Bypass divider setting |

## Verification
The assertions assume that wr_en_i, freq_ok_i and core_locked_i are synchronous to clk_i and stable around each rising edge. They also assume that a write is a single-cycle strobe whose data is valid in the same cycle. The stimulus changes every input only on falling edges and issues no writes while the reset synchronizer is still releasing. Lost-lock events are applied both with and without a concurrent write, so the write-priority properties and the lost-lock properties are each reached on their own.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned MULT_W   = 5;
  localparam int unsigned DIV_W    = 2;
  localparam int unsigned BDIV_W   = 2;
  localparam int unsigned SYNC_LEN = 2;

  localparam int unsigned LOCK_B   = 0;
  localparam int unsigned BRK_B    = 1;
  localparam int unsigned BDIV_LSB = 2;
  localparam int unsigned EN_B     = BDIV_LSB + BDIV_W;
  localparam int unsigned DIV_LSB  = EN_B + 1;
  localparam int unsigned MULT_LSB = DIV_LSB + DIV_W;
  localparam int unsigned RSVD_LO  = MULT_LSB + MULT_W;
  localparam int unsigned IOB_B    = RSVD_LO + 1;

  typedef enum logic [1:0] {
    ST_BYPASS  = 2'd0,
    ST_LOCKING = 2'd1,
    ST_LOCKED  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/clksyn_rst_sync.sv
module clksyn_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/clksyn_regfile.sv
module clksyn_regfile
  import clksyn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              brk_n_i,
  input  logic              lock_i,
  output logic              iob_o,
  output logic              en_o,
  output logic [MULT_W-1:0] mult_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [BDIV_W-1:0] bdiv_o,
  output logic [REG_W-1:0]  rd_data_o
);
  logic              iob_q, iob_d;
  logic              en_q, en_d;
  logic [MULT_W-1:0] mult_q, mult_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [BDIV_W-1:0] bdiv_q, bdiv_d;

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data_i[REG_W-1:IOB_B+1], wr_data_i[RSVD_LO],
                            wr_data_i[BRK_B], wr_data_i[LOCK_B]};

  // next-state values, applied only under the write enable
  always_comb begin
    iob_d  = wr_data_i[IOB_B];
    en_d   = wr_data_i[EN_B];
    mult_d = wr_data_i[MULT_LSB +: MULT_W];
    div_d  = wr_data_i[DIV_LSB +: DIV_W];
    bdiv_d = wr_data_i[BDIV_LSB +: BDIV_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iob_q  <= 1'b1;
      en_q   <= 1'b1;
      mult_q <= '0;
      div_q  <= '0;
      bdiv_q <= '0;
    end else if (wr_en_i) begin
      iob_q  <= iob_d;
      en_q   <= en_d;
      mult_q <= mult_d;
      div_q  <= div_d;
      bdiv_q <= bdiv_d;
    end
  end

  // read word: reserved positions stay zero
  always_comb begin
    rd_data_o                        = '0;
    rd_data_o[IOB_B]                 = iob_q;
    rd_data_o[MULT_LSB +: MULT_W]    = mult_q;
    rd_data_o[DIV_LSB +: DIV_W]      = div_q;
    rd_data_o[EN_B]                  = en_q;
    rd_data_o[BDIV_LSB +: BDIV_W]    = bdiv_q;
    rd_data_o[BRK_B]                 = brk_n_i;
    rd_data_o[LOCK_B]                = lock_i;
  end

  assign iob_o  = iob_q;
  assign en_o   = en_q;
  assign mult_o = mult_q;
  assign div_o  = div_q;
  assign bdiv_o = bdiv_q;

  AST_FIELD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(mult_o) && $stable(div_o) && $stable(bdiv_o))); // R3
endmodule

// File: rtl/clksyn_seq.sv
module clksyn_seq
  import clksyn_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_enable_i,
  input  logic iob_i,
  input  logic en_i,
  input  logic freq_ok_i,
  input  logic core_locked_i,
  output logic sel_synth_o,
  output logic lock_req_o,
  output logic brk_n_o
);
  seq_state_e state_q, state_d;
  logic       boot_q, boot_d;
  logic       req_q, req_d;
  logic       brk_q, brk_d;

  always_comb begin
    state_d = state_q;
    req_d   = 1'b0;
    boot_d  = 1'b0;
    brk_d   = brk_q;
    if (wr_en_i) begin
      brk_d = 1'b1;
      if (wr_enable_i) begin
        state_d = ST_LOCKING;
        req_d   = 1'b1;
      end else begin
        state_d = ST_BYPASS;
      end
    end else begin
      if (core_locked_i) begin
        brk_d = 1'b1;
      end else if (state_q == ST_LOCKED && !iob_i) begin
        brk_d = 1'b0;
      end
      unique case (state_q)
        ST_BYPASS: begin
          if (boot_q && en_i) begin
            state_d = ST_LOCKING;
            req_d   = 1'b1;
          end
        end
        ST_LOCKING: begin
          if (freq_ok_i) state_d = ST_LOCKED;
        end
        ST_LOCKED: begin
          if (!core_locked_i && iob_i) begin
            state_d = ST_LOCKING;
            req_d   = 1'b1;
          end
        end
        default: state_d = ST_BYPASS;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BYPASS;
      req_q   <= 1'b0;
      brk_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      brk_q   <= brk_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q <= 1'b1;
    end else if (boot_q) begin
      boot_q <= boot_d;
    end
  end

  assign sel_synth_o = (state_q == ST_LOCKED);
  assign lock_req_o  = req_q;
  assign brk_n_o     = brk_q;

  AST_REQ_IN_LOCKING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_req_o |-> (state_q == ST_LOCKING)); // R5
  AST_WRITE_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !sel_synth_o); // R4
  AST_LOCK_AFTER_FREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_synth_o) |-> $past(freq_ok_i)); // R6
  AST_DISABLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_enable_i) |=> (!sel_synth_o && !lock_req_o)); // R7
  AST_IOB_RELOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_synth_o && !core_locked_i && iob_i && !wr_en_i) |=> (lock_req_o && !sel_synth_o)); // R8
  AST_BRK_HOLD_SYNTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_synth_o && !core_locked_i && !iob_i && !wr_en_i) |=> (sel_synth_o && !brk_n_o)); // R9
  AST_BRK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i || core_locked_i) |=> brk_n_o); // R10
endmodule

// File: rtl/clksyn_mode_ctrl.sv
module clksyn_mode_ctrl
  import clksyn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              freq_ok_i,
  input  logic              core_locked_i,
  output logic              sel_synth_o,
  output logic              lock_req_o,
  output logic [MULT_W-1:0] mult_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [BDIV_W-1:0] bypass_div_o
);
  logic rst_n_sync;
  logic iob, en, brk_n, sel_synth;

  clksyn_rst_sync #(.STAGES(SYNC_LEN)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  clksyn_regfile u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .brk_n_i   (brk_n),
    .lock_i    (sel_synth),
    .iob_o     (iob),
    .en_o      (en),
    .mult_o    (mult_o),
    .div_o     (div_o),
    .bdiv_o    (bypass_div_o),
    .rd_data_o (rd_data_o)
  );

  clksyn_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_n_sync),
    .wr_en_i       (wr_en_i),
    .wr_enable_i   (wr_data_i[EN_B]),
    .iob_i         (iob),
    .en_i          (en),
    .freq_ok_i     (freq_ok_i),
    .core_locked_i (core_locked_i),
    .sel_synth_o   (sel_synth),
    .lock_req_o    (lock_req_o),
    .brk_n_o       (brk_n)
  );

  assign sel_synth_o = sel_synth;
endmodule

// File: tb/clksyn_mode_ctrl_tb_top.sv
module clksyn_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        freq_ok = 1'b0;
  logic        core_locked = 1'b1;
  logic [15:0] rd_data;
  logic        sel_synth, lock_req;
  logic [4:0]  mult;
  logic [1:0]  div, bdiv;

  int    vectors = 0;
  int    errors  = 0;
  string cur_req = "R1";
  bit    done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clksyn_mode_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .freq_ok_i(freq_ok), .core_locked_i(core_locked),
    .sel_synth_o(sel_synth), .lock_req_o(lock_req), .mult_o(mult),
    .div_o(div), .bypass_div_o(bdiv)
  );

  // behavioural reference: mode 0 bypass, 1 locking, 2 locked
  int       m_mode = 0;
  int       m_rel  = 0;
  bit       m_boot = 1'b1;
  bit       m_req  = 1'b0;
  bit       m_brk  = 1'b1;
  bit       m_iob  = 1'b1;
  bit       m_en   = 1'b1;
  bit [4:0] m_mult = '0;
  bit [1:0] m_div  = '0;
  bit [1:0] m_bd   = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_rel = 0; m_boot = 1; m_req = 0; m_brk = 1;
      m_iob = 1; m_en = 1; m_mult = 0; m_div = 0; m_bd = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      automatic int  old = m_mode;
      automatic bit  old_iob = m_iob;
      automatic bit  start = m_boot;
      m_req  = 0;
      m_boot = 0;
      if (wr_en) begin
        m_iob = wr_data[13]; m_mult = wr_data[11:7]; m_div = wr_data[6:5];
        m_en = wr_data[4]; m_bd = wr_data[3:2]; m_brk = 1;
        if (wr_data[4]) begin m_mode = 1; m_req = 1; end
        else m_mode = 0;
      end else begin
        if (core_locked) m_brk = 1;
        else if (old == 2 && !old_iob) m_brk = 0;
        if (old == 0 && start && m_en) begin m_mode = 1; m_req = 1; end
        else if (old == 1 && freq_ok) m_mode = 2;
        else if (old == 2 && !core_locked && old_iob) begin m_mode = 1; m_req = 1; end
      end
    end
  end

  function automatic logic [15:0] exp_rd();
    return {2'b00, m_iob, 1'b0, m_mult, m_div, m_en, m_bd, m_brk, (m_mode == 2)};
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(cur_req, "rd_data", rd_data, exp_rd());
      chk(cur_req, "sel_synth", {15'd0, sel_synth}, {15'd0, m_mode == 2});
      chk(cur_req, "lock_req", {15'd0, lock_req}, {15'd0, m_req});
      chk(cur_req, "fields", {7'd0, mult, div, bdiv}, {7'd0, m_mult, m_div, m_bd});
    end
  end

  function automatic logic [15:0] mk(bit iob, bit [4:0] mu, bit [1:0] dv, bit en, bit [1:0] bd);
    return {2'b11, iob, 1'b1, mu, dv, en, bd, 2'b11};
  endfunction

  task automatic wr(logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    cur_req = "R1";
    chk("R1", "reset word", rd_data, 16'h2012);
    rst_n = 1'b1;
    cyc(2);
    chk("R1", "bypass before release", {15'd0, sel_synth}, 16'd0);
    cyc(1);
    cur_req = "R5";
    chk("R5", "boot lock request", {15'd0, lock_req}, 16'd1);
    cyc(3);
    cur_req = "R6";
    freq_ok = 1'b1; cyc(1); freq_ok = 1'b0;
    chk("R6", "locked sel", {15'd0, sel_synth}, 16'd1);
    chk("R6", "lock bit", {15'd0, rd_data[0]}, 16'd1);
    // R2 R3 R4 R5: write all-ones reserved bits while locked
    cur_req = "R4";
    wr(mk(1, 5'h13, 2'd2, 1, 2'd1));
    chk("R4", "bypass after write", {15'd0, sel_synth}, 16'd0);
    chk("R5", "restart pulse", {15'd0, lock_req}, 16'd1);
    chk("R2", "reserved zero", rd_data & 16'hD000, 16'h0000);
    chk("R3", "mult out", {11'd0, mult}, 16'h13);
    cyc(1);
    chk("R5", "pulse one cycle", {15'd0, lock_req}, 16'd0);
    // R11: write and freq_ok together, write wins
    cur_req = "R11";
    freq_ok = 1'b1; wr(mk(1, 5'h0A, 2'd3, 1, 2'd2)); freq_ok = 1'b0;
    chk("R11", "write over freq_ok", {15'd0, sel_synth}, 16'd0);
    freq_ok = 1'b1; cyc(1); freq_ok = 1'b0;
    // R8: lost lock with relock policy
    cur_req = "R8";
    core_locked = 1'b0; cyc(1); core_locked = 1'b1;
    chk("R8", "relock request", {15'd0, lock_req}, 16'd1);
    chk("R8", "bypass on loss", {15'd0, sel_synth}, 16'd0);
    cyc(2);
    // R9 R10: hold synthesized clock, break flag
    cur_req = "R9";
    wr(mk(0, 5'h05, 2'd1, 1, 2'd3));
    freq_ok = 1'b1; cyc(1); freq_ok = 1'b0;
    core_locked = 1'b0; cyc(1);
    chk("R9", "synth held", {15'd0, sel_synth}, 16'd1);
    chk("R9", "break low", {15'd0, rd_data[1]}, 16'd0);
    cyc(2);
    cur_req = "R10";
    core_locked = 1'b1; cyc(1);
    chk("R10", "break restored", {15'd0, rd_data[1]}, 16'd1);
    core_locked = 1'b0; cyc(2);
    wr(mk(0, 5'h05, 2'd1, 1, 2'd3));
    chk("R10", "break cleared by write", {15'd0, rd_data[1]}, 16'd1);
    core_locked = 1'b1;
    // R7: disable, freq_ok ignored in bypass
    cur_req = "R7";
    wr(mk(1, 5'h1F, 2'd0, 0, 2'd0));
    chk("R7", "no request", {15'd0, lock_req}, 16'd0);
    freq_ok = 1'b1; cyc(3); freq_ok = 1'b0;
    chk("R7", "stays bypass", {15'd0, sel_synth}, 16'd0);
    // R11: freq_ok while locked has no effect
    cur_req = "R11";
    wr(mk(1, 5'h02, 2'd2, 1, 2'd1));
    freq_ok = 1'b1; cyc(4); freq_ok = 1'b0;
    chk("R11", "locked steady", {15'd0, sel_synth}, 16'd1);
    // mixed traffic against the reference
    cur_req = "R11";
    for (int i = 0; i < 2000; i++) begin
      freq_ok     = ($urandom_range(0, 3) == 0);
      core_locked = ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 15) == 0) wr(16'($urandom));
      else cyc(1);
    end
    freq_ok = 1'b0; core_locked = 1'b1;
    cyc(2);
    finish_run();
  end
endmodule